// File: doc/BRIEF.md
# Mixed-Width Dual-Port Byte/Halfword RAM

This block is a synchronous RAM with a single byte-organised storage array that two independent ports reach at different widths. The byte port reads and writes one 8-bit location per cycle. The halfword port reads and writes an aligned pair of bytes as one 16-bit word. The ports have nothing in common but the storage: each one has its own address, write data, write strobe and read data. The halfword port carries one address bit fewer than the byte port, because its byte address always has a low bit of zero.

Reads are registered on both ports. A port that reads a location it is also writing in the same cycle gets the contents from before the write, and so does a port that reads a byte the other port is writing. When both ports write overlapping bytes in the same cycle, the halfword port's data is kept. A combinational flag reports the overlap during that cycle. The byte-address width is a parameter with a default of 11 bits, which gives 2 KiB of storage.

Top module: `mixed_width_ram`

## Requirements
- R1: Read data on either port appears one clock edge after the address is applied. Changing an address does not alter the read output before the next rising edge.
- R2: Halfword address h covers byte addresses 2h and 2h+1. Byte 2h sits in halfword bits [7:0] and byte 2h+1 in bits [15:8].
- R3: A byte-port write changes only the addressed byte. The other byte of the same halfword keeps its value.
- R4: A halfword-port write stores bits [7:0] at byte 2h and bits [15:8] at byte 2h+1.
- R5: When both ports write in one cycle and the byte address falls inside the halfword, both bytes of that halfword take the halfword port's data.
- R6: `wr_collide` is 1 in exactly those cycles in which both write strobes are high and byte address bits [ADDR_W-1:1] equal the halfword address. In every other cycle it is 0, including cycles with only one write or with writes to different halfwords.
- R7: A port that reads a byte the other port is writing in the same cycle returns the byte's contents from before that write.
- R8: A port that writes and reads the same location in one cycle returns the contents from before the write.
- R9: While reset (active low) is held, both read outputs are zero from the first clock edge onward.
- R10: Writes from both ports to different halfwords in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the read outputs |
| a_addr | input | ADDR_W | Byte-port address |
| a_we | input | 1 | Byte-port write strobe |
| a_wdata | input | 8 | Byte-port write data |
| a_rdata | output | 8 | Byte-port registered read data |
| b_addr | input | ADDR_W-1 | Halfword-port address |
| b_we | input | 1 | Halfword-port write strobe |
| b_wdata | input | 16 | Halfword-port write data |
| b_rdata | output | 16 | Halfword-port registered read data |
| wr_collide | output | 1 | Same-cycle overlapping write indicator |

## Verification
The bench uses a 32-byte configuration and covers every byte and every halfword. It fills the array through one port and reads it back through the other, so a swapped lane order or an off-by-one halfword mapping shows up as bytes returned in the wrong half or from the wrong pair. It forces a collision on both lanes of every halfword. A design that let the byte port win, or merged the two writes, would leave a byte that does not match the halfword data, and a flag decoded from the wrong address bits would stay low or rise on a miss. It also reads each location while it is being written, through both the same port and the other port, so a write-first read path shows up as fresh data where old data belongs.

// File: rtl/mwram_pkg.sv
package mwram_pkg;
   parameter int LANE_W = 8;
   parameter int LANES  = 2;
   typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/mwram_lane.sv
module mwram_lane
   import mwram_pkg::*;
#(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] a_row,
   input  logic             a_wr,
   input  lane_t            a_wdata,
   input  logic [ROW_W-1:0] b_row,
   input  logic             b_wr,
   input  lane_t            b_wdata,
   output lane_t            a_q,
   output lane_t            b_q
);
   localparam int DEPTH = 2 ** ROW_W;

   lane_t mem [DEPTH];
   logic  a_yield;

   // byte port gives way only when the halfword port writes the same row
   assign a_yield = b_wr && (a_row == b_row);

   always_ff @(posedge clk) begin
      if (a_wr && !a_yield) mem[a_row] <= a_wdata;
      if (b_wr)             mem[b_row] <= b_wdata;
   end

   // read-before-write: array is sampled before this edge's updates land
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         a_q <= mem[a_row];
         b_q <= mem[b_row];
      end
   end
endmodule

// File: rtl/mwram_collide.sv
module mwram_collide #(
   parameter int ROW_W = 10
) (
   input  logic [ROW_W-1:0] a_row,
   input  logic             a_we,
   input  logic [ROW_W-1:0] b_row,
   input  logic             b_we,
   output logic             hit
);
   always_comb hit = a_we && b_we && (a_row == b_row);
endmodule

// File: rtl/mwram_rdmux.sv
module mwram_rdmux
   import mwram_pkg::*;
#(
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_in,
   input  lane_t            lane_q [LANES],
   output lane_t            dout
);
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel_in;
   end

   always_comb dout = lane_q[sel_q];
endmodule

// File: rtl/mixed_width_ram.sv
module mixed_width_ram
   import mwram_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   a_addr,
   input  logic                a_we,
   input  logic [LANE_W-1:0]   a_wdata,
   output logic [LANE_W-1:0]   a_rdata,
   input  logic [ADDR_W-2:0]   b_addr,
   input  logic                b_we,
   input  logic [2*LANE_W-1:0] b_wdata,
   output logic [2*LANE_W-1:0] b_rdata,
   output logic                wr_collide
);
   localparam int ROW_W = ADDR_W - 1;
   localparam int SEL_W = $clog2(LANES);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mixed_width_ram: ADDR_W must be at least 2");
      end
      if (LANES != 2 || SEL_W != 1) begin : g_bad_lanes
         $error("mixed_width_ram: exactly two byte lanes are supported");
      end
   endgenerate

   logic [ROW_W-1:0] a_row;
   logic [SEL_W-1:0] a_lane;
   lane_t            a_lane_q [LANES];

   assign a_row  = a_addr[ADDR_W-1:SEL_W];
   assign a_lane = a_addr[SEL_W-1:0];

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic a_wr_l;
         assign a_wr_l = a_we && (a_lane == SEL_W'(l));

         mwram_lane #(.ROW_W(ROW_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_row   (a_row),
            .a_wr    (a_wr_l),
            .a_wdata (a_wdata),
            .b_row   (b_addr),
            .b_wr    (b_we),
            .b_wdata (b_wdata[l*LANE_W +: LANE_W]),
            .a_q     (a_lane_q[l]),
            .b_q     (b_rdata[l*LANE_W +: LANE_W])
         );
      end
   endgenerate

   mwram_rdmux #(.SEL_W(SEL_W)) u_rdmux (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_in (a_lane),
      .lane_q (a_lane_q),
      .dout   (a_rdata)
   );

   mwram_collide #(.ROW_W(ROW_W)) u_collide (
      .a_row (a_row),
      .a_we  (a_we),
      .b_row (b_addr),
      .b_we  (b_we),
      .hit   (wr_collide)
   );
endmodule

// File: rtl/mixed_width_ram_chk.sv
module mixed_width_ram_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] a_addr,
   input logic              a_we,
   input logic [7:0]        a_rdata,
   input logic [ADDR_W-2:0] b_addr,
   input logic              b_we,
   input logic [15:0]       b_wdata,
   input logic [15:0]       b_rdata,
   input logic              wr_collide
);
   // R6
   collide_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we && b_we && (a_addr[ADDR_W-1:1] == b_addr)) |-> wr_collide);

   // R6
   collide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_we && b_we) |-> !wr_collide);

   // R2 R7
   lane_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_addr[ADDR_W-1:1] == b_addr) |=>
         (a_rdata == ($past(a_addr[0]) ? b_rdata[15:8] : b_rdata[7:0])));

   // R4 R5
   half_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_we ##1 (b_addr == $past(b_addr)) |=> (b_rdata == $past(b_wdata, 2)));
endmodule

bind mixed_width_ram mixed_width_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .a_addr     (a_addr),
   .a_we       (a_we),
   .a_rdata    (a_rdata),
   .b_addr     (b_addr),
   .b_we       (b_we),
   .b_wdata    (b_wdata),
   .b_rdata    (b_rdata),
   .wr_collide (wr_collide)
);

// File: tb/mixed_width_ram_bench.sv
`timescale 1ns/1ps
module mixed_width_ram_bench;
   localparam int AW    = 5;
   localparam int BYTES = 2 ** AW;
   localparam int HALFS = BYTES / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] a_addr = '0;
   logic          a_we = 1'b0;
   logic [7:0]    a_wdata = '0;
   logic [7:0]    a_rdata;
   logic [AW-2:0] b_addr = '0;
   logic          b_we = 1'b0;
   logic [15:0]   b_wdata = '0;
   logic [15:0]   b_rdata;
   logic          wr_collide;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int model [BYTES];

   always #2.5 clk = ~clk;

   mixed_width_ram #(.ADDR_W(AW)) u_mixed_width_ram (
      .clk(clk), .rst_n(rst_n),
      .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
      .wr_collide(wr_collide)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      a_we = 1'b0;
      b_we = 1'b0;
   endtask

   function automatic int half_of(input int h);
      return (model[2*h+1] << 8) | model[2*h];
   endfunction

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R9: outputs clear under reset
      repeat (3) tick();
      check("R9 a_rdata", a_rdata, 0);
      check("R9 b_rdata", b_rdata, 0);
      check("R6 idle flag", wr_collide, 0);
      rst_n = 1'b1;

      // fill every byte through the byte port
      for (int i = 0; i < BYTES; i++) begin
         a_addr = AW'(i); a_we = 1'b1; a_wdata = 8'((i * 37 + 5) & 255);
         #1 check("R6 single write flag", wr_collide, 0);
         model[i] = (i * 37 + 5) & 255;
         tick();
      end
      idle();

      // R2: read halfwords back, byte port reads in reverse
      for (int h = 0; h < HALFS; h++) begin
         b_addr = (AW-1)'(h);
         a_addr = AW'(BYTES - 1 - h);
         tick();
         check("R2 halfword lane order", b_rdata, half_of(h));
         check("R1 byte read", a_rdata, model[BYTES - 1 - h]);
      end

      // R1: address change has no effect before the edge
      a_addr = AW'(3);
      tick();
      a_addr = AW'(20);
      #1 check("R1 no early change", a_rdata, model[3]);
      tick();
      check("R1 new data after edge", a_rdata, model[20]);

      // halfword writes everywhere; byte port reads the written byte (R7)
      for (int h = 0; h < HALFS; h++) begin
         int nv;
         int oldh;
         int oldb;
         nv   = (h * 1234 + 77) & 16'hffff;
         oldh = half_of(h);
         oldb = model[2*h + (h & 1)];
         b_addr = (AW-1)'(h); b_we = 1'b1; b_wdata = 16'(nv);
         a_addr = AW'(2*h + (h & 1));
         tick();
         check("R7 byte read during halfword write", a_rdata, oldb);
         check("R8 halfword read during own write", b_rdata, oldh);
         model[2*h]     = nv & 255;
         model[2*h + 1] = (nv >> 8) & 255;
      end
      idle();

      // R4: every byte shows the halfword data
      for (int i = 0; i < BYTES; i++) begin
         a_addr = AW'(i);
         tick();
         check("R4 byte from halfword write", a_rdata, model[i]);
      end

      // byte writes with cross-port read, then neighbour check
      for (int i = 0; i < BYTES; i++) begin
         int oldh;
         int oldb;
         oldh = half_of(i / 2);
         oldb = model[i];
         a_addr = AW'(i); a_we = 1'b1; a_wdata = 8'((i * 91 + 13) & 255);
         b_addr = (AW-1)'(i / 2);
         tick();
         check("R7 halfword read during byte write", b_rdata, oldh);
         check("R8 byte read during own write", a_rdata, oldb);
         model[i] = (i * 91 + 13) & 255;
         a_we = 1'b0;
         tick();
         check("R3 neighbour byte kept", b_rdata, half_of(i / 2));
      end

      // R5/R6: collisions on both lanes of every halfword
      for (int h = 0; h < HALFS; h++) begin
         for (int l = 0; l < 2; l++) begin
            int nv;
            nv = (h * 4099 + l * 611 + 3) & 16'hffff;
            a_addr = AW'(2*h + l); a_we = 1'b1; a_wdata = 8'(~nv);
            b_addr = (AW-1)'(h);   b_we = 1'b1; b_wdata = 16'(nv);
            #1 check("R6 collision flag", wr_collide, 1);
            tick();
            idle();
            model[2*h]     = nv & 255;
            model[2*h + 1] = (nv >> 8) & 255;
            tick();
            check("R5 halfword wins", b_rdata, nv);
            check("R5 byte port sees winner", a_rdata, model[2*h + l]);
         end
      end

      // R10/R6: simultaneous writes to different halfwords
      for (int h = 0; h < HALFS; h++) begin
         int hb;
         int nv;
         int bv;
         hb = (h + 1) % HALFS;
         nv = (h * 300 + 9) & 16'hffff;
         bv = (h * 17 + 200) & 255;
         a_addr = AW'(2*h + 1); a_we = 1'b1; a_wdata = 8'(bv);
         b_addr = (AW-1)'(hb);  b_we = 1'b1; b_wdata = 16'(nv);
         #1 check("R6 no flag on distinct halfwords", wr_collide, 0);
         tick();
         idle();
         model[2*h + 1]  = bv;
         model[2*hb]     = nv & 255;
         model[2*hb + 1] = (nv >> 8) & 255;
         b_addr = (AW-1)'(h);
         a_addr = AW'(2*hb + 1);
         tick();
         check("R10 byte write kept", b_rdata, half_of(h));
         check("R10 halfword write kept", a_rdata, model[2*hb + 1]);
      end

      // R9: reset again clears outputs
      rst_n = 1'b0;
      tick();
      check("R9 a_rdata reset", a_rdata, 0);
      check("R9 b_rdata reset", b_rdata, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule